// File: doc/BRIEF.md
# Variable-Length Instruction Byte Decoder

This block sits at the fetch stage of a small processor. It receives a six-byte window of instruction memory read at the current program counter, together with a flag that reports a fault on that fetch. From the high nibble of the first byte alone it works out how long the instruction is, which bytes hold the register specifiers and which bytes hold the 32-bit constant. It then produces the separated fields, the address of the next sequential instruction and a status code. The status code tells the later stages whether execution can go on normally.

The decoder is purely combinational. Register specifiers that the instruction does not use come out as 0xF, the "no register" value. The constant is zero when the instruction carries none. An opcode it does not know, or a function code that is out of range for its opcode, is reported as an invalid instruction. Executing the instruction, reading registers and accessing data memory belong to other blocks.

Top module: `instr_byte_decoder`

## Requirements
- R1: Byte k of the window is `instWin[8k+7:8k]` (byte 0 in the low bits). `icode` is bits 7:4 of byte 0 and `ifun` is bits 3:0 of byte 0, always passed through unchanged.
- R2: `instLen` is 1 for opcodes 0x0, 0x1 and 0x9; 2 for 0x2, 0x6, 0xA and 0xB; 5 for 0x7 and 0x8; 6 for 0x3, 0x4 and 0x5.
- R3: `rA` is the high nibble of byte 1 and `rB` is its low nibble, for opcodes 0x2, 0x4, 0x5 and 0x6. Opcode 0x3 gives `rA`=0xF and `rB` from the low nibble. Opcodes 0xA and 0xB give `rA` from the high nibble and `rB`=0xF. All other opcodes give 0xF for both.
- R4: `valC` is the little-endian word in bytes 1..4 for opcodes 0x7 and 0x8, and in bytes 2..5 for opcodes 0x3, 0x4 and 0x5. Otherwise it is zero, and the bytes that the instruction does not cover have no effect.
- R5: `valP` equals `pc + instLen` modulo 2^32.
- R6: Opcodes 0x2 and 0x7 accept function codes 0..6, and opcode 0x6 accepts 0..3. Every other known opcode accepts only function code 0. A function code out of range, or any opcode 0xC..0xF, makes the instruction invalid.
- R7: `status` follows a fixed priority. It is 3 (address fault) when `fetchFault` is 1. Otherwise it is 4 (invalid) when R6 marks the instruction invalid, 2 (halted) for byte 0 equal to 0x00, and 1 (normal) in every other case.
- R8: When `status` is 3 or 4, `rA` and `rB` are 0xF, `valC` is 0 and `instLen` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instWin | input | 48 | Six fetched bytes, byte 0 in the low bits |
| pc | input | 32 | Address of byte 0 |
| fetchFault | input | 1 | Instruction memory reported a bad address |
| icode | output | 4 | Opcode nibble |
| ifun | output | 4 | Function code nibble |
| rA | output | 4 | First register specifier, 0xF if unused |
| rB | output | 4 | Second register specifier, 0xF if unused |
| valC | output | 32 | Constant word, 0 if absent |
| valP | output | 32 | Address of the next sequential instruction |
| instLen | output | 3 | Instruction length in bytes |
| status | output | 3 | 1 normal, 2 halted, 3 address fault, 4 invalid |

## Verification
The bench checks the two constant positions against each other. A jump or call must take its word from byte 1, while a memory move must take it from byte 2; a decoder that used one fixed offset would misread one group, and the junk placed in the unused trailing byte would show up in `valC`. It probes each function code limit on both sides (jump with 6 and 7, ALU with 3 and 4, nop with 1), because an off-by-one range check would pass or reject the wrong one. It also checks that an address fault outranks both halt and invalid, that the unused specifier of immediate loads, pushes and pops reads 0xF, and that a next-address sum near the top of the address space wraps to a small value.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
  localparam int ADDR_W  = 32;
  localparam int WORD_W  = 32;
  localparam int NIB_W   = 4;
  localparam int WIN_BYTES = 6;
  localparam int WIN_W   = 8 * WIN_BYTES;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int LEN_W   = 3;
  localparam int STAT_W  = 3;

  localparam logic [NIB_W-1:0] OP_HALT  = 4'h0;
  localparam logic [NIB_W-1:0] OP_NOP   = 4'h1;
  localparam logic [NIB_W-1:0] OP_MOVE  = 4'h2;
  localparam logic [NIB_W-1:0] OP_IMM   = 4'h3;
  localparam logic [NIB_W-1:0] OP_STORE = 4'h4;
  localparam logic [NIB_W-1:0] OP_LOAD  = 4'h5;
  localparam logic [NIB_W-1:0] OP_ALU   = 4'h6;
  localparam logic [NIB_W-1:0] OP_JUMP  = 4'h7;
  localparam logic [NIB_W-1:0] OP_CALL  = 4'h8;
  localparam logic [NIB_W-1:0] OP_RET   = 4'h9;
  localparam logic [NIB_W-1:0] OP_PUSH  = 4'hA;
  localparam logic [NIB_W-1:0] OP_POP   = 4'hB;

  localparam logic [NIB_W-1:0] NO_REG   = 4'hF;

  localparam logic [STAT_W-1:0] ST_OK   = 3'd1;
  localparam logic [STAT_W-1:0] ST_HALT = 3'd2;
  localparam logic [STAT_W-1:0] ST_ADDR = 3'd3;
  localparam logic [STAT_W-1:0] ST_BAD  = 3'd4;

  typedef struct packed {
    logic             useRa;
    logic             useRb;
    logic             hasRegByte;
    logic             hasConst;
    logic [LEN_W-1:0] len;
  } decStrobeT;
endpackage

// File: rtl/ivd_ctrl.sv
module ivd_ctrl
  import ivd_pkg::*;
(
  input  logic [NIB_W-1:0]  opCode,
  input  logic [NIB_W-1:0]  fnCode,
  input  logic              fetchFault,
  output decStrobeT         strobe,
  output logic [STAT_W-1:0] status
);
  logic knownOp;
  logic fnOk;
  logic instOk;
  decStrobeT raw;

  // R6: opcode and function code legality
  always_comb begin
    knownOp = (opCode <= OP_POP);
    unique case (opCode)
      OP_MOVE, OP_JUMP: fnOk = (fnCode <= 4'd6);
      OP_ALU:           fnOk = (fnCode <= 4'd3);
      default:          fnOk = (fnCode == 4'd0);
    endcase
    instOk = knownOp && fnOk;
  end

  // R2, R3: which fields the opcode carries
  always_comb begin
    raw = '0;
    unique case (opCode)
      OP_MOVE, OP_STORE, OP_LOAD, OP_ALU: begin
        raw.useRa = 1'b1;
        raw.useRb = 1'b1;
      end
      OP_IMM:         raw.useRb = 1'b1;
      OP_PUSH, OP_POP: raw.useRa = 1'b1;
      default: ;
    endcase
    unique case (opCode)
      OP_IMM, OP_STORE, OP_LOAD, OP_JUMP, OP_CALL: raw.hasConst = 1'b1;
      default: raw.hasConst = 1'b0;
    endcase
    raw.hasRegByte = raw.useRa | raw.useRb;
    raw.len = LEN_W'(1) + LEN_W'(raw.hasRegByte) + (raw.hasConst ? LEN_W'(WORD_BYTES) : LEN_W'(0));
  end

  // R7, R8: status priority and field suppression
  always_comb begin
    if (fetchFault) begin
      status = ST_ADDR;
    end else if (!instOk) begin
      status = ST_BAD;
    end else if (opCode == OP_HALT) begin
      status = ST_HALT;
    end else begin
      status = ST_OK;
    end
    if (fetchFault || !instOk) begin
      strobe = '{useRa: 1'b0, useRb: 1'b0, hasRegByte: 1'b0, hasConst: 1'b0, len: LEN_W'(1)};
    end else begin
      strobe = raw;
    end
  end

  always_comb begin
    // R2: only the four legal lengths may appear
    a_r2_len_legal: assert (strobe.len == 3'd1 || strobe.len == 3'd2 ||
                            strobe.len == 3'd5 || strobe.len == 3'd6)
      else $error("length %0d outside legal set", strobe.len);
    // R7: halted status only for a clean fetch of opcode 0 with function 0
    a_r7_halt_src: assert (status != ST_HALT || (!fetchFault && opCode == OP_HALT && fnCode == 4'd0))
      else $error("halt status from wrong source");
    // R8: a faulting or invalid fetch carries no fields
    a_r8_bad_empty: assert ((status != ST_ADDR && status != ST_BAD) ||
                            (!strobe.hasConst && !strobe.hasRegByte))
      else $error("fields enabled on bad fetch");
  end
endmodule

// File: rtl/ivd_dpath.sv
module ivd_dpath
  import ivd_pkg::*;
(
  input  logic [WIN_W-1:0]  instWin,
  input  logic [ADDR_W-1:0] pc,
  input  decStrobeT         strobe,
  output logic [NIB_W-1:0]  rA,
  output logic [NIB_W-1:0]  rB,
  output logic [WORD_W-1:0] valC,
  output logic [ADDR_W-1:0] valP
);
  logic [7:0] regByte;
  logic [WORD_W-1:0] wordEarly;
  logic [WORD_W-1:0] wordLate;
  logic [ADDR_W-1:0] step;

  assign regByte = instWin[15:8];
  assign rA = strobe.useRa ? regByte[7:4] : NO_REG;
  assign rB = strobe.useRb ? regByte[3:0] : NO_REG;

  // R4: little-endian constant at byte 1 or byte 2
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_cbyte
    assign wordEarly[8*k +: 8] = instWin[8*(k+1) +: 8];
    assign wordLate[8*k +: 8]  = instWin[8*(k+2) +: 8];
  end

  assign valC = !strobe.hasConst ? '0 : (strobe.hasRegByte ? wordLate : wordEarly);

  // R5: next sequential address, wrapping
  assign valP = pc + ADDR_W'(strobe.len);
  assign step = valP - pc;

  always_comb begin
    // R5: distance to next instruction is between 1 and 6 bytes even across wrap
    a_r5_step_range: assert (step >= ADDR_W'(1) && step <= ADDR_W'(WIN_BYTES))
      else $error("next address step %0d out of range", step);
    // R4: a constant implies a long instruction
    a_r4_const_long: assert (valC == '0 || step >= ADDR_W'(5))
      else $error("constant on short instruction");
  end
endmodule

// File: rtl/instr_byte_decoder.sv
module instr_byte_decoder
  import ivd_pkg::*;
(
  input  logic [47:0] instWin,
  input  logic [31:0] pc,
  input  logic        fetchFault,
  output logic [3:0]  icode,
  output logic [3:0]  ifun,
  output logic [3:0]  rA,
  output logic [3:0]  rB,
  output logic [31:0] valC,
  output logic [31:0] valP,
  output logic [2:0]  instLen,
  output logic [2:0]  status
);
  decStrobeT strobe;

  // R1: opcode and function nibbles of byte 0
  assign icode   = instWin[7:4];
  assign ifun    = instWin[3:0];
  assign instLen = strobe.len;

  ivd_ctrl u_ctrl (
    .opCode    (icode),
    .fnCode    (ifun),
    .fetchFault(fetchFault),
    .strobe    (strobe),
    .status    (status)
  );

  ivd_dpath u_dpath (
    .instWin(instWin),
    .pc     (pc),
    .strobe (strobe),
    .rA     (rA),
    .rB     (rB),
    .valC   (valC),
    .valP   (valP)
  );

  always_comb begin
    // R7: an address fault outranks every other status
    a_r7_fault_wins: assert (!fetchFault || status == ST_ADDR)
      else $error("fault not reported");
    // R3: unused register slots read as no-register on invalid opcodes
    a_r3_bad_noreg: assert (status != ST_BAD || (rA == NO_REG && rB == NO_REG))
      else $error("register field on invalid instruction");
  end
endmodule

// File: tb/sim_instr_byte_decoder.sv
module sim_instr_byte_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [47:0] instWin;
  logic [31:0] pc;
  logic fetchFault;
  logic [3:0] icode, ifun, rA, rB;
  logic [31:0] valC, valP;
  logic [2:0] instLen, status;
  int nChk = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  instr_byte_decoder u0 (
    .instWin(instWin), .pc(pc), .fetchFault(fetchFault),
    .icode(icode), .ifun(ifun), .rA(rA), .rB(rB),
    .valC(valC), .valP(valP), .instLen(instLen), .status(status)
  );

  function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  task automatic cmp(input string tag, input string fld, input logic [31:0] act, exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
    end
  endtask

  task automatic drive(input logic [47:0] w, input logic [31:0] p, input logic f);
    @(negedge clk);
    instWin = w; pc = p; fetchFault = f;
    #2;
  endtask

  task automatic expectAll(input string tag, input logic [3:0] eI, eF, eA, eB,
                           input logic [31:0] eC, eP, input logic [2:0] eL, eS);
    cmp(tag, "icode", 32'(icode), 32'(eI));
    cmp(tag, "ifun", 32'(ifun), 32'(eF));
    cmp(tag, "rA", 32'(rA), 32'(eA));
    cmp(tag, "rB", 32'(rB), 32'(eB));
    cmp(tag, "valC", valC, eC);
    cmp(tag, "valP", valP, eP);
    cmp(tag, "instLen", 32'(instLen), 32'(eL));
    cmp(tag, "status", 32'(status), 32'(eS));
  endtask

  task automatic t_reset;
    expectAll("R7 reset-zero-halt", 4'h0, 4'h0, 4'hF, 4'hF, 32'h0, 32'h1, 3'd1, 3'd2);
  endtask

  task automatic t_alu;
    drive(mk(8'h60, 8'h06, 8'hAA, 8'hBB, 8'hCC, 8'hDD), 32'h100, 1'b0);
    expectAll("R1 R3 alu add", 4'h6, 4'h0, 4'h0, 4'h6, 32'h0, 32'h102, 3'd2, 3'd1);
    drive(mk(8'h63, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00), 32'h200, 1'b0);
    expectAll("R6 alu fn3 ok", 4'h6, 4'h3, 4'h1, 4'h2, 32'h0, 32'h202, 3'd2, 3'd1);
    drive(mk(8'h64, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00), 32'h200, 1'b0);
    expectAll("R6 R8 alu fn4 bad", 4'h6, 4'h4, 4'hF, 4'hF, 32'h0, 32'h201, 3'd1, 3'd4);
  endtask

  task automatic t_const_moves;
    drive(mk(8'h30, 8'h82, 8'hCD, 8'hAB, 8'h00, 8'h00), 32'h10, 1'b0);
    expectAll("R3 R4 imm", 4'h3, 4'h0, 4'hF, 4'h2, 32'h0000ABCD, 32'h16, 3'd6, 3'd1);
    drive(mk(8'h50, 8'h15, 8'hF4, 8'hFF, 8'hFF, 8'hFF), 32'h20, 1'b0);
    expectAll("R4 load neg disp", 4'h5, 4'h0, 4'h1, 4'h5, 32'hFFFFFFF4, 32'h26, 3'd6, 3'd1);
    drive(mk(8'h40, 8'h64, 8'h1C, 8'h04, 8'h00, 8'h00), 32'h30, 1'b0);
    expectAll("R2 R4 store", 4'h4, 4'h0, 4'h6, 4'h4, 32'h0000041C, 32'h36, 3'd6, 3'd1);
  endtask

  task automatic t_branches;
    drive(mk(8'h80, 8'h28, 8'h00, 8'h00, 8'h00, 8'hEE), 32'h0C, 1'b0);
    expectAll("R4 call early const", 4'h8, 4'h0, 4'hF, 4'hF, 32'h28, 32'h11, 3'd5, 3'd1);
    drive(mk(8'h76, 8'h78, 8'h56, 8'h34, 8'h12, 8'h99), 32'h40, 1'b0);
    expectAll("R6 jump fn6 ok", 4'h7, 4'h6, 4'hF, 4'hF, 32'h12345678, 32'h45, 3'd5, 3'd1);
    drive(mk(8'h77, 8'h78, 8'h56, 8'h34, 8'h12, 8'h99), 32'h40, 1'b0);
    expectAll("R6 jump fn7 bad", 4'h7, 4'h7, 4'hF, 4'hF, 32'h0, 32'h41, 3'd1, 3'd4);
    drive(mk(8'h90, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 32'h50, 1'b0);
    expectAll("R2 ret", 4'h9, 4'h0, 4'hF, 4'hF, 32'h0, 32'h51, 3'd1, 3'd1);
  endtask

  task automatic t_stack_move;
    drive(mk(8'hA0, 8'h4F, 8'h11, 8'h11, 8'h11, 8'h11), 32'h60, 1'b0);
    expectAll("R3 push", 4'hA, 4'h0, 4'h4, 4'hF, 32'h0, 32'h62, 3'd2, 3'd1);
    drive(mk(8'hB0, 8'h3F, 8'h11, 8'h11, 8'h11, 8'h11), 32'h70, 1'b0);
    expectAll("R3 pop", 4'hB, 4'h0, 4'h3, 4'hF, 32'h0, 32'h72, 3'd2, 3'd1);
    drive(mk(8'h26, 8'h43, 8'h11, 8'h11, 8'h11, 8'h11), 32'h80, 1'b0);
    expectAll("R3 cmov fn6", 4'h2, 4'h6, 4'h4, 4'h3, 32'h0, 32'h82, 3'd2, 3'd1);
  endtask

  task automatic t_invalid;
    drive(mk(8'h11, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), 32'h90, 1'b0);
    expectAll("R6 nop fn1 bad", 4'h1, 4'h1, 4'hF, 4'hF, 32'h0, 32'h91, 3'd1, 3'd4);
    drive(mk(8'hC0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A), 32'hA0, 1'b0);
    expectAll("R6 opcode C bad", 4'hC, 4'h0, 4'hF, 4'hF, 32'h0, 32'hA1, 3'd1, 3'd4);
    drive(mk(8'h10, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF), 32'hB0, 1'b0);
    expectAll("R2 nop", 4'h1, 4'h0, 4'hF, 4'hF, 32'h0, 32'hB1, 3'd1, 3'd1);
  endtask

  task automatic t_fault;
    drive(mk(8'h30, 8'h82, 8'hCD, 8'hAB, 8'h00, 8'h00), 32'hC0, 1'b1);
    expectAll("R7 R8 fault on imm", 4'h3, 4'h0, 4'hF, 4'hF, 32'h0, 32'hC1, 3'd1, 3'd3);
    drive(mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), 32'hD0, 1'b1);
    expectAll("R7 fault beats halt", 4'h0, 4'h0, 4'hF, 4'hF, 32'h0, 32'hD1, 3'd1, 3'd3);
    drive(mk(8'hF5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), 32'hE0, 1'b1);
    expectAll("R7 fault beats invalid", 4'hF, 4'h5, 4'hF, 4'hF, 32'h0, 32'hE1, 3'd1, 3'd3);
  endtask

  task automatic t_wrap;
    drive(mk(8'h30, 8'hF1, 8'h01, 8'h00, 8'h00, 8'h00), 32'hFFFFFFFE, 1'b0);
    expectAll("R5 wrap", 4'h3, 4'h0, 4'hF, 4'h1, 32'h1, 32'h4, 3'd6, 3'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog all-R actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    instWin = '0; pc = '0; fetchFault = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    t_reset();
    t_alu();
    t_const_moves();
    t_branches();
    t_stack_move();
    t_invalid();
    t_fault();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule